// File: doc/BRIEF.md
# Timeslot Cross-Connect Switching Element

This block is one element of a two-by-two byte cross-connect. Two byte streams, bus A and bus B, arrive in step with a repeating frame of `NSLOT` timeslots. Each stream is stored in its own double-buffered time switch. While one page of each switch fills at the current timeslot index, the other page is read at an address that the host chose for that timeslot. In a full chip both input buses also feed the matching switch of the other element.

A host-writable connection table holds a 4-bit source code and a read address for every outgoing timeslot. The source code picks the output byte. It can be switch A data, switch B data, the byte on a pass-through bus, or an idle byte taken from a second table that holds one byte per timeslot. Writing all ones into the idle byte, for example, produces a tributary alarm pattern. A switch drives its read data and raises its enable only in the timeslots that select it, so its unselected output stays at zero.

A three-state frame controller governs the output. The states are WAIT_SYNC, FILL and RUN. After reset the element is in WAIT_SYNC. A frame pulse causes the transition SYNC_SEEN, which moves it to FILL. In FILL one full page is written. At the next natural frame wrap the transition FRAME_DONE moves it to RUN. A frame pulse that does not fall on the expected wrap causes the transition REALIGN, which takes RUN back to FILL, or restarts FILL.

Top module: `xcx_element`

## Requirements
- R1: After reset, and in WAIT_SYNC until the first `fsync`, `dout` is 0x00 and both switch enables are low.
- R2: A cycle with `fsync` high is timeslot 0. Without `fsync` the timeslot counts up by one each cycle and returns from NSLOT-1 to 0 by itself.
- R3: Bus A and bus B bytes are written at the current timeslot index into the write page. Reads use the other page. The pages swap at every timeslot 0. After SYNC_SEEN, output starts at the first natural wrap, which is one full frame later.
- R4: Source code 0 outputs the byte that bus A wrote at the entry's read address in the previous frame, and raises `sw_a_en`.
- R5: Source code 1 does the same from bus B, and raises `sw_b_en`.
- R6: Source code 2 outputs the `din_pass` byte of that timeslot, and both enables are low.
- R7: Source code 3 outputs the idle-table byte stored for that timeslot index.
- R8: Source codes 4 to 15 output 0x00 with both enables low.
- R9: `sw_a_en` and `sw_b_en` are never high together, and each is high only in the timeslots that select its switch.
- R10: With code 0 or 1, a read address of NSLOT or more outputs 0x00 while the selected enable is still high.
- R11: A host write with `cfg_sel`=0 stores {code in bits 12:9, read address in bits 8:0} for entry `cfg_addr`. A write with `cfg_sel`=1 stores `cfg_wdata[7:0]` as that timeslot's idle byte. The new value takes effect from the next cycle, so a timeslot read in the same cycle uses the old value. Writes to an address of NSLOT or more are ignored.
- R12: An `fsync` that arrives when the counter is not at NSLOT-1 restarts the count at 0 (REALIGN). The output is 0x00 from that cycle until the next natural wrap.
- R13: The output and enables for a timeslot appear one clock after the cycle in which that timeslot's inputs are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | Frame pulse; marks timeslot 0 |
| din_a | input | 8 | Bus A byte for the current timeslot |
| din_b | input | 8 | Bus B byte for the current timeslot |
| din_pass | input | 8 | Pass-through bus byte |
| cfg_we | input | 1 | Host table write strobe |
| cfg_sel | input | 1 | 0 = connection table, 1 = idle table |
| cfg_addr | input | 9 | Table entry (timeslot) |
| cfg_wdata | input | 13 | Table write data |
| dout | output | 8 | Output byte, one cycle late |
| sw_a_en | output | 1 | Switch A drives this output timeslot |
| sw_b_en | output | 1 | Switch B drives this output timeslot |

## Verification
Two functions can fall in the same cycle. A host table write can target the very entry being read, and the counter can wrap at the same edge as a frame pulse, aligned or misaligned. The bench steers about half of its random table writes onto the timeslot that is currently active. It judges the output against a model that applies writes only after that timeslot's read. Frame pulses are given both on the natural wrap and off it, and each is judged by whether the output stays valid or goes to zero for one frame.

// File: rtl/xcx_pkg.sv
package xcx_pkg;

    // frame controller states
    typedef enum logic [1:0] {
        FS_WAIT = 2'd0,
        FS_FILL = 2'd1,
        FS_RUN  = 2'd2
    } fsm_e;

    // decoded output source, one stage ahead of dout
    typedef enum logic [2:0] {
        SEL_ZERO = 3'd0,
        SEL_A    = 3'd1,
        SEL_B    = 3'd2,
        SEL_PASS = 3'd3,
        SEL_IDLE = 3'd4
    } sel_e;

    localparam int SRC_W = 4;
    localparam logic [SRC_W-1:0] CODE_SW_A = 4'd0;
    localparam logic [SRC_W-1:0] CODE_SW_B = 4'd1;
    localparam logic [SRC_W-1:0] CODE_PASS = 4'd2;
    localparam logic [SRC_W-1:0] CODE_IDLE = 4'd3;

endpackage

// File: rtl/xcx_timing.sv
module xcx_timing
    import xcx_pkg::*;
#(
    parameter int NSLOT  = 270,
    parameter int SLOT_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    output logic [SLOT_W-1:0] cur_slot,
    output logic              wr_page,
    output logic              rd_ok
);

    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NSLOT - 1);

    fsm_e              state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    logic              page_q;
    logic              wrap_hit;
    logic              misalign;

    assign wrap_hit = (slot_q == LAST);
    assign misalign = fsync && !wrap_hit;
    assign cur_slot = (fsync || wrap_hit) ? '0 : slot_q + SLOT_W'(1);
    assign wr_page  = (fsync || wrap_hit) ? ~page_q : page_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_WAIT;
            slot_q  <= LAST;
            page_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            slot_q  <= cur_slot;
            page_q  <= wr_page;
        end
    end

    // transitions: SYNC_SEEN, FRAME_DONE, REALIGN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_WAIT: if (fsync)    state_d = FS_FILL;
            FS_FILL: if (wrap_hit) state_d = FS_RUN;
            FS_RUN:  if (misalign) state_d = FS_FILL;
            default:               state_d = FS_WAIT;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            FS_WAIT: rd_ok = 1'b0;
            FS_FILL: rd_ok = wrap_hit;
            FS_RUN:  rd_ok = !misalign;
            default: rd_ok = 1'b0;
        endcase
    end

    a_r1_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_WAIT && !fsync) |=> (state_q == FS_WAIT));

    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == LAST && !fsync) |=> (slot_q == '0));

    a_r3_page_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync || slot_q == LAST) |=> (page_q != $past(page_q)));

    a_r12_realign: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_RUN && fsync && slot_q != LAST) |=> (state_q == FS_FILL && slot_q == '0));

endmodule

// File: rtl/xcx_cfg_store.sv
module xcx_cfg_store
    import xcx_pkg::*;
#(
    parameter int NSLOT  = 270,
    parameter int DW     = 8,
    parameter int SLOT_W = 9,
    parameter int CFG_W  = SRC_W + SLOT_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic              sel,
    input  logic [SLOT_W-1:0] addr,
    input  logic [CFG_W-1:0]  wdata,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [SRC_W-1:0]  code,
    output logic [SLOT_W-1:0] rd_addr,
    output logic [DW-1:0]     idle_byte
);

    logic [CFG_W-1:0] conn_tbl [NSLOT];
    logic [DW-1:0]    idle_tbl [NSLOT];
    logic             addr_ok;

    assign addr_ok = int'(addr) < NSLOT;

    always_ff @(posedge clk) begin
        if (we && addr_ok && !sel) conn_tbl[addr] <= wdata;
        if (we && addr_ok &&  sel) idle_tbl[addr] <= wdata[DW-1:0];
    end

    assign code      = conn_tbl[rd_slot][CFG_W-1:SLOT_W];
    assign rd_addr   = conn_tbl[rd_slot][SLOT_W-1:0];
    assign idle_byte = idle_tbl[rd_slot];

endmodule

// File: rtl/xcx_time_switch.sv
module xcx_time_switch #(
    parameter int NSLOT  = 270,
    parameter int DW     = 8,
    parameter int SLOT_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     wr_data,
    input  logic              wr_page,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [SLOT_W-1:0] rd_addr,
    input  logic              req,
    output logic              en_q,
    output logic [DW-1:0]     rd_q
);

    logic [DW-1:0] mem [2][NSLOT];
    logic          addr_ok;

    assign addr_ok = int'(rd_addr) < NSLOT;

    always_ff @(posedge clk) begin
        mem[wr_page][wr_slot] <= wr_data;
    end

    // read data is gated to zero whenever the switch is not selected
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            rd_q <= '0;
        end else begin
            en_q <= req;
            rd_q <= (req && addr_ok) ? mem[!wr_page][rd_addr] : '0;
        end
    end

    a_r10_range: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !addr_ok) |=> (en_q && rd_q == '0));

endmodule

// File: rtl/xcx_element.sv
module xcx_element
    import xcx_pkg::*;
#(
    parameter  int NSLOT  = 270,
    parameter  int DW     = 8,
    localparam int SLOT_W = $clog2(NSLOT),
    localparam int CFG_W  = SRC_W + SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic [DW-1:0]     din_a,
    input  logic [DW-1:0]     din_b,
    input  logic [DW-1:0]     din_pass,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [SLOT_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [DW-1:0]     dout,
    output logic              sw_a_en,
    output logic              sw_b_en
);

    localparam int NSW = 2;

    logic [SLOT_W-1:0] cur_slot;
    logic              wr_page;
    logic              rd_ok;
    logic [SRC_W-1:0]  code;
    logic [SLOT_W-1:0] rd_addr;
    logic [DW-1:0]     idle_byte;
    sel_e              sel_d, sel_q;
    logic [DW-1:0]     pass_q, idle_q;
    logic [DW-1:0]     sw_din [NSW];
    logic [DW-1:0]     sw_rd  [NSW];
    logic [NSW-1:0]    sw_req, sw_en;

    xcx_timing #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_timing (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync    (fsync),
        .cur_slot (cur_slot),
        .wr_page  (wr_page),
        .rd_ok    (rd_ok)
    );

    xcx_cfg_store #(.NSLOT(NSLOT), .DW(DW), .SLOT_W(SLOT_W), .CFG_W(CFG_W)) u_cfg (
        .clk       (clk),
        .we        (cfg_we),
        .sel       (cfg_sel),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .rd_slot   (cur_slot),
        .code      (code),
        .rd_addr   (rd_addr),
        .idle_byte (idle_byte)
    );

    // source decode for the timeslot being presented
    always_comb begin
        sel_d = SEL_ZERO;
        if (rd_ok) begin
            unique case (code)
                CODE_SW_A: sel_d = SEL_A;
                CODE_SW_B: sel_d = SEL_B;
                CODE_PASS: sel_d = SEL_PASS;
                CODE_IDLE: sel_d = SEL_IDLE;
                default:   sel_d = SEL_ZERO;
            endcase
        end
    end

    assign sw_din[0] = din_a;
    assign sw_din[1] = din_b;
    assign sw_req[0] = (sel_d == SEL_A);
    assign sw_req[1] = (sel_d == SEL_B);

    for (genvar g = 0; g < NSW; g++) begin : g_sw
        xcx_time_switch #(.NSLOT(NSLOT), .DW(DW), .SLOT_W(SLOT_W)) u_sw (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_data (sw_din[g]),
            .wr_page (wr_page),
            .wr_slot (cur_slot),
            .rd_addr (rd_addr),
            .req     (sw_req[g]),
            .en_q    (sw_en[g]),
            .rd_q    (sw_rd[g])
        );
    end

    // pass-through and idle bytes registered to match the switch read stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= SEL_ZERO;
            pass_q <= '0;
            idle_q <= '0;
        end else begin
            sel_q  <= sel_d;
            pass_q <= din_pass;
            idle_q <= (sel_d == SEL_IDLE) ? idle_byte : '0;
        end
    end

    always_comb begin
        unique case (sel_q)
            SEL_A:    dout = sw_rd[0];
            SEL_B:    dout = sw_rd[1];
            SEL_PASS: dout = pass_q;
            SEL_IDLE: dout = idle_q;
            default:  dout = '0;
        endcase
    end

    assign sw_a_en = sw_en[0];
    assign sw_b_en = sw_en[1];

    a_r9_one_switch: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_en[0] && sw_en[1]));

    a_r4_a_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == SEL_A) |-> (sw_en[0] && !sw_en[1]));

    a_r5_b_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == SEL_B) |-> (sw_en[1] && !sw_en[0]));

    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == SEL_ZERO) |-> (sw_en == '0 && sw_rd[0] == '0 && sw_rd[1] == '0));

endmodule

// File: tb/sim_xcx_element.sv
module sim_xcx_element;

    localparam int NSLOT  = 270;
    localparam int SLOT_W = 9;
    localparam int CFG_W  = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fsync = 1'b0;
    logic [7:0]        din_a = '0, din_b = '0, din_pass = '0;
    logic              cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [SLOT_W-1:0] cfg_addr = '0;
    logic [CFG_W-1:0]  cfg_wdata = '0;
    logic [7:0]        dout;
    logic              sw_a_en, sw_b_en;

    always #5 clk = ~clk;

    xcx_element u0 (
        .clk(clk), .rst_n(rst_n), .fsync(fsync),
        .din_a(din_a), .din_b(din_b), .din_pass(din_pass),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .dout(dout), .sw_a_en(sw_a_en), .sw_b_en(sw_b_en)
    );

    // reference model state
    logic [7:0] ma [2][NSLOT];
    logic [7:0] mb [2][NSLOT];
    logic [3:0] m_code [NSLOT];
    logic [8:0] m_addr [NSLOT];
    logic [7:0] m_idle [NSLOT];
    int         m_slot = NSLOT - 1;
    logic       m_page = 1'b0;
    int         m_state = 0;   // 0 WAIT_SYNC, 1 FILL, 2 RUN
    bit         realigned = 0;

    int    n_run = 0, n_fail = 0;
    bit    exp_valid = 0;
    logic [7:0] exp_dout;
    logic  exp_ea, exp_eb;
    string exp_tag;

    function automatic int slot_of(input logic fs);
        return (fs || m_slot == NSLOT - 1) ? 0 : m_slot + 1;
    endfunction

    function automatic logic [12:0] rand_entry();
        int r = $urandom % 16;
        logic [3:0] c;
        logic [8:0] a;
        if (r < 4)       c = 4'd0;
        else if (r < 8)  c = 4'd1;
        else if (r < 10) c = 4'd2;
        else if (r < 13) c = 4'd3;
        else             c = 4'(4 + $urandom % 12);
        if ($urandom % 8 == 0) a = 9'(NSLOT + $urandom % (512 - NSLOT));
        else                   a = 9'($urandom % NSLOT);
        return {c, a};
    endfunction

    // outputs for cycle k are checked at the falling edge after one rising edge (R13)
    task automatic check_prev();
        if (exp_valid) begin
            n_run++;
            if (dout !== exp_dout || sw_a_en !== exp_ea || sw_b_en !== exp_eb) begin
                n_fail++;
                $display("FAIL %s (R13 timing): dout=%h en=%b%b expected dout=%h en=%b%b",
                         exp_tag, dout, sw_a_en, sw_b_en, exp_dout, exp_ea, exp_eb);
            end
        end
    endtask

    task automatic step(input logic fs, input logic we, input logic sel,
                        input int addr, input logic [12:0] wd);
        int cur, rp;
        logic page, mis, wrap, ok;
        @(negedge clk);
        check_prev();
        fsync = fs; cfg_we = we; cfg_sel = sel;
        cfg_addr = 9'(addr); cfg_wdata = wd;
        din_a = 8'($urandom); din_b = 8'($urandom); din_pass = 8'($urandom);
        wrap = (m_slot == NSLOT - 1);
        mis  = fs && !wrap;
        cur  = slot_of(fs);
        page = (cur == 0) ? ~m_page : m_page;
        rp   = int'(!page);
        case (m_state)
            1:       ok = wrap;
            2:       ok = !mis;
            default: ok = 1'b0;
        endcase
        exp_ea = 0; exp_eb = 0; exp_dout = '0;
        if (!ok) begin
            exp_tag = (m_state == 0) ? "R1" : (realigned ? "R12" : "R3");
        end else begin
            case (m_code[cur])
                4'd0: begin
                    exp_ea = 1;
                    if (m_addr[cur] >= NSLOT) exp_tag = "R10";
                    else begin exp_dout = ma[rp][m_addr[cur]]; exp_tag = "R3,R4,R9"; end
                end
                4'd1: begin
                    exp_eb = 1;
                    if (m_addr[cur] >= NSLOT) exp_tag = "R10";
                    else begin exp_dout = mb[rp][m_addr[cur]]; exp_tag = "R3,R5,R9"; end
                end
                4'd2: begin exp_dout = din_pass; exp_tag = "R6"; end
                4'd3: begin exp_dout = m_idle[cur]; exp_tag = "R2,R7"; end
                default: exp_tag = "R8";
            endcase
        end
        if (we && addr == cur) exp_tag = {exp_tag, ",R11"};
        exp_valid = 1;
        // state updates that land at the coming edge
        ma[page][cur] = din_a;
        mb[page][cur] = din_b;
        if (we && addr < NSLOT) begin
            if (!sel) begin m_code[addr] = wd[12:9]; m_addr[addr] = wd[8:0]; end
            else m_idle[addr] = wd[7:0];
        end
        case (m_state)
            0: if (fs) m_state = 1;
            1: if (wrap) begin m_state = 2; realigned = 0; end
            2: if (mis) begin m_state = 1; realigned = 1; end
            default: m_state = 0;
        endcase
        m_slot = cur;
        m_page = page;
    endtask

    task automatic rnd_step(input logic fs);
        int r = $urandom % 8;
        int a;
        if (r < 2) begin
            // half the writes hit the timeslot being read this cycle (R11)
            a = ($urandom % 2 == 0) ? slot_of(fs) : int'($urandom % 300);
            step(fs, 1'b1, r[0], a, (r[0]) ? 13'($urandom) : rand_entry());
        end else begin
            step(fs, 1'b0, 1'b0, 0, '0);
        end
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // reset state (R1)
        repeat (3) @(negedge clk);
        n_run++;
        if (dout !== 8'h00 || sw_a_en !== 1'b0 || sw_b_en !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: dout=%h en=%b%b expected dout=00 en=00", dout, sw_a_en, sw_b_en);
        end
        rst_n = 1'b1;
        // program both tables while waiting for sync (R1, R11)
        for (int i = 0; i < NSLOT; i++) step(1'b0, 1'b1, 1'b0, i, rand_entry());
        for (int i = 0; i < NSLOT; i++) step(1'b0, 1'b1, 1'b1, i, 13'($urandom));
        // directed: table writes beyond the last timeslot are ignored (R11)
        step(1'b0, 1'b1, 1'b1, NSLOT + 5, 13'h0ff);
        step(1'b0, 1'b1, 1'b0, 511, 13'h0003);
        // directed: slot 7 all-ones idle, slot 8 out-of-range switch A read (R7, R10)
        step(1'b0, 1'b1, 1'b0, 7, {4'd3, 9'd0});
        step(1'b0, 1'b1, 1'b1, 7, 13'h0ff);
        step(1'b0, 1'b1, 1'b0, 8, {4'd0, 9'd400});
        step(1'b0, 1'b1, 1'b0, 9, {4'd9, 9'd1});
        // first frame pulse (SYNC_SEEN), then FILL and RUN
        step(1'b1, 1'b0, 1'b0, 0, '0);
        // two frames with aligned pulses (R2, R3)
        for (int i = 0; i < 2 * NSLOT; i++) rnd_step(m_slot == NSLOT - 1);
        // three frames with no pulses: free wrap (R2)
        for (int i = 0; i < 3 * NSLOT; i++) rnd_step(1'b0);
        // misaligned pulse mid-frame (R12), then recovery
        for (int i = 0; i < 100; i++) rnd_step(1'b0);
        step(1'b1, 1'b0, 1'b0, 0, '0);
        for (int i = 0; i < 3 * NSLOT; i++) rnd_step(1'b0);
        // misaligned pulse during FILL restarts the fill (R12)
        step(1'b1, 1'b0, 1'b0, 0, '0);
        for (int i = 0; i < 50; i++) rnd_step(1'b0);
        step(1'b1, 1'b0, 1'b0, 0, '0);
        for (int i = 0; i < 2 * NSLOT; i++) rnd_step(m_slot == NSLOT - 1);
        @(negedge clk);
        check_prev();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule